// File: doc/BRIEF.md
# PHY Statistics Counter Register Bank

This block is the statistics and control register bank of a 10/100 Ethernet PHY, read and written by management logic. It counts three receive-side events from the PHY datapath: false-carrier indications, link disconnects, and received frames that carry at least one error. It also returns a fixed PHY address and holds three 10BASE-T control bits, which it drives straight out to the datapath.

Each counter is 16 bits wide. A counter stops at 16'hFFFF instead of wrapping, and a read of the counter clears it. When an event arrives in the same cycle as the read that clears its counter, the event is kept, so the counter holds 1 afterwards. The error-frame counter counts frames, not errors. An internal flag marks a frame that has already been counted. A frame-start pulse opens a new frame and re-arms the flag. A frame-end pulse also re-arms it.

Register port: 5-bit address, read strobe, write strobe, 16-bit write data. The read data is registered. It shows the addressed value in the cycle after the read strobe and is 0 in every other cycle. Reset is synchronous and active-high.

Top module: `phy_stat_regs`

## Requirements
- R1: While reset is high, and in the cycle after it, all counters are 0, all three control outputs are 0 and the read data is 16'h0000.
- R2: The false-carrier counter at address 19 increments by one for each clock cycle in which its event input is high.
- R3: The disconnect counter at address 20 increments by one for each clock cycle in which its event input is high.
- R4: The error-frame counter at address 21 increments at most once per frame. It counts only the first cycle with the error input high after a frame-start pulse or a frame-end pulse. An error in the same cycle as a frame-start pulse counts for the new frame. An error in the same cycle as a frame-end pulse counts for the ending frame, if that frame was not already counted.
- R5: Every counter holds at 16'hFFFF when further events arrive. It never wraps.
- R6: A read of a counter address returns the counter's value before the read, one cycle after the strobe, and clears that counter. An event in the same cycle as the read leaves the counter at 1.
- R7: A read of address 18 returns 16'h0001. The PHY address sits in bits 4:0 and bits 15:5 are 0.
- R8: Address 17 is the control register. Bit 2 drives ext_squelch_en_o, bit 1 drives link_check_off_o and bit 0 drives jabber_off_o. A write takes effect one cycle after the strobe. Reads return those three bits with bits 15:3 as 0.
- R9: A write to any address other than 17 changes no counter and no control output.
- R10: A read of any address other than 17 to 21 returns 16'h0000 and changes no counter.
- R11: In any cycle after a cycle without a read strobe, the read data is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| false_carrier_i | input | 1 | False-carrier event, one count per high cycle |
| disconnect_i | input | 1 | Disconnect event, one count per high cycle |
| frame_start_i | input | 1 | Start-of-frame pulse |
| frame_end_i | input | 1 | End-of-frame pulse |
| rx_error_i | input | 1 | Receive error within the current frame |
| reg_addr_i | input | 5 | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| ext_squelch_en_o | output | 1 | Extended squelch enable |
| link_check_off_o | output | 1 | Link integrity disable |
| jabber_off_o | output | 1 | Jabber function disable |

## Verification
The hardest condition to reach from the ports is saturation. It takes 65,535 events before a counter reaches its limit. The bench drives all three event sources together for more than 65,535 cycles, with a frame-start pulse and an error in every cycle, so that the frame counter also advances every cycle. All three counters reach the limit in one run, and the reads that follow show them held at 16'hFFFF. The other awkward case is an event in the same cycle as the read that clears its counter. The bench creates it on purpose for each counter and then checks the following read.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int CNT_W   = 16;
    localparam int NUM_CNT = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd17;
    localparam logic [ADDR_W-1:0] A_PHYADDR = 5'd18;
    localparam logic [ADDR_W-1:0] A_CNT0    = 5'd19;

    typedef enum int {
        CNT_FALSE_CARRIER = 0,
        CNT_DISCONNECT    = 1,
        CNT_ERR_FRAME     = 2
    } cnt_idx_e;

    typedef struct packed {
        logic ext_squelch;
        logic link_off;
        logic jabber_off;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ext_squelch: 1'b0, link_off: 1'b0, jabber_off: 1'b0};

    function automatic logic [ADDR_W-1:0] cnt_addr(input int idx);
        return A_CNT0 + ADDR_W'(idx);
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ext_squelch = w[2];
        c.link_off    = w[1];
        c.jabber_off  = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DATA_W-3){1'b0}}, c.ext_squelch, c.link_off, c.jabber_off};
    endfunction

endpackage

// File: rtl/phy_stat_sat_cnt.sv
module phy_stat_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr_i) begin
            cnt_d = inc_i ? W'(1) : '0;
        end else if (inc_i && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/phy_stat_frm_err.sv
module phy_stat_frm_err (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic end_i,
    input  logic err_i,
    output logic count_o
);
    logic seen_q;
    logic seen_d;

    assign count_o = err_i && (start_i || !seen_q);

    always_comb begin
        if (end_i) begin
            seen_d = 1'b0;
        end else if (start_i) begin
            seen_d = err_i;
        end else begin
            seen_d = seen_q || err_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
    import phy_stat_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              false_carrier_i,
    input  logic              disconnect_i,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic              rx_error_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              ext_squelch_en_o,
    output logic              link_check_off_o,
    output logic              jabber_off_o
);
    logic [NUM_CNT-1:0]            evt;
    logic [NUM_CNT-1:0]            clr;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic                          frm_err_cnt;
    ctrl_t                         ctrl_q;
    logic [DATA_W-1:0]             rd_val;
    logic [DATA_W-1:0]             rdata_q;

    phy_stat_frm_err u_frm_err (
        .clk     (clk),
        .rst     (rst),
        .start_i (frame_start_i),
        .end_i   (frame_end_i),
        .err_i   (rx_error_i),
        .count_o (frm_err_cnt)
    );

    assign evt[CNT_FALSE_CARRIER] = false_carrier_i;
    assign evt[CNT_DISCONNECT]    = disconnect_i;
    assign evt[CNT_ERR_FRAME]     = frm_err_cnt;

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        assign clr[gi] = reg_rd_i && (reg_addr_i == cnt_addr(gi));

        phy_stat_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc_i (evt[gi]),
            .clr_i (clr[gi]),
            .cnt_o (cnt_q[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (reg_wr_i && (reg_addr_i == A_CTRL)) begin
            ctrl_q <= ctrl_from_word(reg_wdata_i);
        end
    end

    always_comb begin
        rd_val = '0;
        if (reg_addr_i == A_CTRL) begin
            rd_val = ctrl_to_word(ctrl_q);
        end
        if (reg_addr_i == A_PHYADDR) begin
            rd_val = {{(DATA_W-5){1'b0}}, PHY_ADDR};
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr_i == cnt_addr(i)) begin
                rd_val = cnt_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= reg_rd_i ? rd_val : '0;
        end
    end

    assign reg_rdata_o      = rdata_q;
    assign ext_squelch_en_o = ctrl_q.ext_squelch;
    assign link_check_off_o = ctrl_q.link_off;
    assign jabber_off_o     = ctrl_q.jabber_off;
endmodule

// File: rtl/phy_stat_regs_chk.sv
module phy_stat_regs_chk
    import phy_stat_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input logic                          clk,
    input logic                          rst,
    input logic [ADDR_W-1:0]             reg_addr_i,
    input logic                          reg_rd_i,
    input logic                          reg_wr_i,
    input logic [DATA_W-1:0]             reg_rdata_o,
    input logic                          ext_squelch_en_o,
    input logic                          link_check_off_o,
    input logic                          jabber_off_o,
    input logic [NUM_CNT-1:0]            evt,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
    // R11: no read strobe, no read data
    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_i |=> (reg_rdata_o == '0));

    // R7: fixed address register
    p_phyaddr_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_addr_i == A_PHYADDR) |=> (reg_rdata_o == {11'd0, PHY_ADDR}));

    // R9: control outputs move only on a control write
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_i && reg_addr_i == A_CTRL)
        |=> $stable({ext_squelch_en_o, link_check_off_o, jabber_off_o}));

    // R10: unmapped reads return zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && (reg_addr_i < A_CTRL || reg_addr_i > A_CNT0 + 5'd2))
        |=> (reg_rdata_o == '0));

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_chk
        // R5: a full counter stays full unless cleared
        p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[gi] == {CNT_W{1'b1}} && !(reg_rd_i && reg_addr_i == cnt_addr(gi)))
            |=> (cnt_q[gi] == {CNT_W{1'b1}}));

        // R6: a read leaves the counter at 0 or 1, set by a coincident event
        p_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (reg_rd_i && reg_addr_i == cnt_addr(gi))
            |=> (cnt_q[gi] == CNT_W'($past(evt[gi]))));
    end
endmodule

bind phy_stat_regs phy_stat_regs_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .reg_addr_i       (reg_addr_i),
    .reg_rd_i         (reg_rd_i),
    .reg_wr_i         (reg_wr_i),
    .reg_rdata_o      (reg_rdata_o),
    .ext_squelch_en_o (ext_squelch_en_o),
    .link_check_off_o (link_check_off_o),
    .jabber_off_o     (jabber_off_o),
    .evt              (evt),
    .cnt_q            (cnt_q)
);

// File: tb/test_phy_stat_regs.sv
`timescale 1ns/1ps
module test_phy_stat_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fc = 0, dc = 0, fs = 0, fe = 0, er = 0;
    logic [4:0]  addr = '0;
    logic        rd = 0, wr = 0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        o_sq, o_lk, o_jb;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt[3];
    bit m_flag;
    int m_ctrl;
    int m_rd;

    always #2 clk = ~clk;

    phy_stat_regs i_phy_stat_regs (
        .clk(clk), .rst(rst),
        .false_carrier_i(fc), .disconnect_i(dc),
        .frame_start_i(fs), .frame_end_i(fe), .rx_error_i(er),
        .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ext_squelch_en_o(o_sq), .link_check_off_o(o_lk), .jabber_off_o(o_jb)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input bit i_fc, input bit i_dc, input bit i_fs, input bit i_fe,
                        input bit i_er, input bit i_rd, input bit i_wr,
                        input int i_addr, input int i_wd, input string tag);
        bit ev[3];
        fc = i_fc; dc = i_dc; fs = i_fs; fe = i_fe; er = i_er;
        rd = i_rd; wr = i_wr; addr = 5'(i_addr); wdata = 16'(i_wd);
        @(posedge clk);
        m_rd = 0;
        if (i_rd) begin
            case (i_addr)
                17: m_rd = m_ctrl;
                18: m_rd = 1;
                19: m_rd = m_cnt[0];
                20: m_rd = m_cnt[1];
                21: m_rd = m_cnt[2];
                default: m_rd = 0;
            endcase
        end
        ev[0] = i_fc;
        ev[1] = i_dc;
        ev[2] = i_er && (i_fs || !m_flag);
        if (i_fe) m_flag = 0;
        else if (i_fs) m_flag = i_er;
        else m_flag = m_flag | i_er;
        for (int k = 0; k < 3; k++) begin
            if (i_rd && i_addr == 19 + k) m_cnt[k] = ev[k] ? 1 : 0;
            else if (ev[k] && m_cnt[k] < 65535) m_cnt[k]++;
        end
        if (i_wr && i_addr == 17) m_ctrl = i_wd & 7;
        @(negedge clk);
        check({tag, " rdata"}, rdata, m_rd);
        check({tag, " ctrl"}, {o_sq, o_lk, o_jb}, m_ctrl);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0,0,0,0,0,0,0,0,0,tag);
    endtask

    task automatic rdreg(input int a, input string tag);
        step(0,0,0,0,0,1,0,a,0,tag);
    endtask

    task automatic wrreg(input int a, input int d, input string tag);
        step(0,0,0,0,0,0,1,a,d,tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) m_cnt[k] = 0;
        m_flag = 0; m_ctrl = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", rdata, 0);
        check("R1 reset ctrl", {o_sq, o_lk, o_jb}, 0);
        rst = 1'b0;
        idle(1, "R1");
        rdreg(19, "R1"); rdreg(20, "R1"); rdreg(21, "R1");

        // R2: false carrier events, bursts and gaps
        for (int k = 0; k < 7; k++) step(k != 3,0,0,0,0,0,0,0,0,"R2");
        rdreg(19, "R2"); idle(1, "R11"); rdreg(19, "R2");

        // R3: disconnect events
        for (int k = 0; k < 9; k++) step(0,k[0],0,0,0,0,0,0,0,"R3");
        rdreg(20, "R3");

        // R4: frame error counting
        step(0,0,1,0,0,0,0,0,0,"R4");
        step(0,0,0,0,1,0,0,0,0,"R4");
        step(0,0,0,0,1,0,0,0,0,"R4");
        step(0,0,0,0,0,0,0,0,0,"R4");
        step(0,0,0,0,1,0,0,0,0,"R4");
        step(0,0,0,1,0,0,0,0,0,"R4");   // end of frame 1 (counted once)
        step(0,0,1,0,0,0,0,0,0,"R4");
        step(0,0,0,1,0,0,0,0,0,"R4");   // clean frame 2
        step(0,0,1,0,1,0,0,0,0,"R4");   // error on start of frame 3
        step(0,0,0,0,1,0,0,0,0,"R4");
        step(0,0,0,1,1,0,0,0,0,"R4");   // error on end, already counted
        step(0,0,1,0,0,0,0,0,0,"R4");
        step(0,0,0,1,1,0,0,0,0,"R4");   // error only on end cycle of frame 4
        step(0,0,1,1,0,0,0,0,0,"R4");
        step(0,0,1,0,1,0,0,0,0,"R4");   // back-to-back starts with errors
        step(0,0,1,0,1,0,0,0,0,"R4");
        rdreg(21, "R4");

        // R6: event coincident with the clearing read
        step(1,0,0,0,0,0,0,0,0,"R6");
        step(1,0,0,0,0,1,0,19,0,"R6");
        rdreg(19, "R6");
        step(0,1,0,0,0,1,0,20,0,"R6");
        rdreg(20, "R6");
        step(0,0,1,0,1,1,0,21,0,"R6");
        rdreg(21, "R6");

        // R7
        rdreg(18, "R7");

        // R8: control register
        wrreg(17, 16'h0005, "R8");
        rdreg(17, "R8");
        wrreg(17, 16'hFFFA, "R8");
        rdreg(17, "R8");
        step(0,0,0,0,0,1,1,17,16'h0004,"R8");   // read and write together
        rdreg(17, "R8");

        // R9: writes elsewhere ignored
        for (int k = 0; k < 4; k++) step(1,1,1,0,1,0,0,0,0,"R9");
        for (int a = 0; a < 32; a++) if (a != 17) wrreg(a, 16'hFFFF, "R9");
        rdreg(19, "R9"); rdreg(20, "R9"); rdreg(21, "R9"); rdreg(17, "R9");

        // R10: unmapped reads
        step(1,1,0,0,0,0,0,0,0,"R10");
        rdreg(0, "R10"); rdreg(16, "R10"); rdreg(22, "R10"); rdreg(31, "R10");
        rdreg(19, "R10"); rdreg(20, "R10");

        // R5: saturate all three counters at once
        for (int k = 0; k < 65540; k++) step(1,1,1,0,1,0,0,0,0,"R5");
        idle(2, "R5");
        rdreg(19, "R5"); rdreg(20, "R5"); rdreg(21, "R5");
        rdreg(19, "R5"); idle(3, "R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule